// File: doc/BRIEF.md
# Data-Enable Panel Timing Generator

This block produces all timing for an 800x600 thin-film panel driven in data-enable mode from a single pixel clock of about 40 MHz (nominal 39.79 MHz, period about 25.13 ns, duty cycle between 40% and 60%). A horizontal counter and a vertical counter scan a raster. Each line opens with horizontal blanking and then runs 800 active clocks. Each frame opens with a configurable number of vertical blanking lines and then runs 600 active lines. The data-enable output is high only on active pixels of active lines.

Pixels come from an upstream source over a ready/valid handshake. Each pixel is 18 bits: red in bits [17:12], green in [11:6] and blue in [5:0]. Outside the data-enable window the colour output is zero. If the source fails to supply a pixel when one is due, the block outputs black for that pixel and raises a sticky error flag.

Clock position 0 of each line is the line-start reference. The block derives four gate-driver strobes at fixed offsets from it: a frame start pulse, a gate clock, a gate output enable and a drive polarity line. All outputs are registered, so each output shows the raster position the counters held one clock earlier.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: A synchronous reset, active high, clears every output to 0, including the error flag and the polarity. The counters restart at position 0 of line 0, which is the first vertical blanking line, so pixReady is 0 during reset.
- R2: On every active line, lcdDe is high for exactly H_ACTIVE consecutive clocks (800 by default), at line positions H_TOTAL-H_ACTIVE through H_TOTAL-1. On blanking lines it stays low.
- R3: Each frame contains exactly V_ACTIVE lines with data enable (600 by default), and these follow directly after the vertical blanking lines.
- R4: The number of vertical blanking lines is vBlankLines clamped to the range 10 to 110. The value is taken at reset and at each frame boundary, so a change in mid-frame takes effect from the next frame.
- R5: pixReady is high exactly when the counters sit on an active pixel. A pixel offered with pixValid high while pixReady is high appears on lcdRgb, with lcdDe high, one clock later.
- R6: While lcdDe is low, lcdRgb is all zeros.
- R7: If pixReady is high and pixValid is low, the next output pixel is black and underflowErr goes high. underflowErr then stays high until reset.
- R8: On active lines, gateOe is high for line positions 23 to 172 (150 clocks) and gateClk for positions 40 to 172 (133 clocks). Both are low on blanking lines.
- R9: gateStart is high for exactly one line period once per frame. It rises at position 4 of the first active line and falls at position 4 of the next line.
- R10: At position 157 of every line, polarity takes the value (line index bit 0) XOR (frame parity). The frame parity is 0 after reset and toggles at each frame boundary, so polarity changes once per line and its phase inverts every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vBlankLines | input | VB_IN_W (7) | Requested vertical blanking lines, clamped to 10..110 |
| pixValid | input | 1 | Upstream pixel available |
| pixData | input | 3*COLOR_W (18) | Upstream pixel, red [17:12], green [11:6], blue [5:0] |
| pixReady | output | 1 | Pixel accepted at this clock edge if valid |
| lcdDe | output | 1 | Panel data enable |
| lcdRgb | output | 3*COLOR_W (18) | Panel colour data, zero outside data enable |
| gateStart | output | 1 | Frame start pulse for the gate driver |
| gateClk | output | 1 | Gate driver shift clock |
| gateOe | output | 1 | Gate driver output enable |
| polarity | output | 1 | Drive polarity, inverted per line and per frame |
| underflowErr | output | 1 | Sticky flag: a due pixel was not supplied |

## Verification
pixReady is combinational from the counters, so the bench reads it on the falling edge before the clock edge that consumes the offered pixel. Every other output is registered and changes on the first rising edge after the counters reach a position. The bench keeps its own raster position for the values now on the outputs, compares all outputs one time unit after each rising edge, and only then advances that position. Line totals, frame totals and the number of blanking lines before the first data-enable line are checked when the bench's own position wraps. A change to the blanking request takes effect at the clock edge where that wrap occurs.

// File: rtl/lcdtc_pkg.sv
`timescale 1ns/1ps
package lcdtc_pkg;

  // Per-position decode handed from control to datapath
  typedef struct packed {
    logic active;   // current counter position is a visible pixel
    logic stv;      // frame start level for this position
    logic ckv;      // gate clock level
    logic oev;      // gate output enable level
    logic polLoad;  // polarity update point of the line
    logic polVal;   // value loaded at the update point
  } tcStrobes_t;

endpackage

// File: rtl/lcdtc_scan.sv
`timescale 1ns/1ps
module lcdtc_scan #(
  parameter int H_TOTAL  = 1056,
  parameter int V_ACTIVE = 600,
  parameter int VB_MIN   = 10,
  parameter int VB_MAX   = 110,
  parameter int VB_IN_W  = 7,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_ACTIVE + VB_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VB_IN_W-1:0] vBlankLines,
  output logic [HW-1:0]      hCount,
  output logic [VW-1:0]      vCount,
  output logic [VW-1:0]      vbCur,
  output logic               frameOdd
);

  localparam logic [VB_IN_W-1:0] VB_MIN_IN = VB_IN_W'(VB_MIN);
  localparam logic [VB_IN_W-1:0] VB_MAX_IN = VB_IN_W'(VB_MAX);

  logic [VW-1:0] vbClamped;
  logic          lineEnd;
  logic          frameEnd;

  always_comb begin
    if (vBlankLines < VB_MIN_IN)      vbClamped = VW'(VB_MIN);
    else if (vBlankLines > VB_MAX_IN) vbClamped = VW'(VB_MAX);
    else                              vbClamped = VW'(vBlankLines);
  end

  assign lineEnd  = (hCount == HW'(H_TOTAL - 1));
  assign frameEnd = lineEnd && (vCount == vbCur + VW'(V_ACTIVE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount   <= '0;
      vCount   <= '0;
      vbCur    <= vbClamped;
      frameOdd <= 1'b0;
    end else begin
      if (lineEnd) hCount <= '0;
      else         hCount <= hCount + HW'(1);
      if (frameEnd) begin
        vCount   <= '0;
        vbCur    <= vbClamped;
        frameOdd <= ~frameOdd;
      end else if (lineEnd) begin
        vCount <= vCount + VW'(1);
      end
    end
  end

endmodule

// File: rtl/lcdtc_ctrl.sv
`timescale 1ns/1ps
module lcdtc_ctrl
  import lcdtc_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_TOTAL  = 1056,
  parameter int V_ACTIVE = 600,
  parameter int VB_MIN   = 10,
  parameter int VB_MAX   = 110,
  parameter int VB_IN_W  = 7,
  parameter int STV_OFS  = 4,
  parameter int OEV_OFS  = 23,
  parameter int OEV_W    = 150,
  parameter int CKV_OFS  = 40,
  parameter int CKV_W    = 133,
  parameter int POL_OFS  = 157
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VB_IN_W-1:0] vBlankLines,
  output tcStrobes_t         strobes
);

  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_ACTIVE + VB_MAX + 1);
  localparam int H_BLANK = H_TOTAL - H_ACTIVE;

  logic [HW-1:0] hCount;
  logic [VW-1:0] vCount;
  logic [VW-1:0] vbCur;
  logic          frameOdd;
  logic          vActive;
  logic          firstLine;
  logic          secondLine;

  lcdtc_scan #(
    .H_TOTAL (H_TOTAL),
    .V_ACTIVE(V_ACTIVE),
    .VB_MIN  (VB_MIN),
    .VB_MAX  (VB_MAX),
    .VB_IN_W (VB_IN_W)
  ) uScan (
    .clk        (clk),
    .rst        (rst),
    .vBlankLines(vBlankLines),
    .hCount     (hCount),
    .vCount     (vCount),
    .vbCur      (vbCur),
    .frameOdd   (frameOdd)
  );

  assign vActive    = (vCount >= vbCur) && (vCount < vbCur + VW'(V_ACTIVE));
  assign firstLine  = (vCount == vbCur);
  assign secondLine = (vCount == vbCur + VW'(1));

  always_comb begin
    strobes.active  = vActive && (hCount >= HW'(H_BLANK));
    strobes.stv     = (firstLine && (hCount >= HW'(STV_OFS))) ||
                      (secondLine && (hCount < HW'(STV_OFS)));
    strobes.oev     = vActive && (hCount >= HW'(OEV_OFS)) &&
                      (hCount < HW'(OEV_OFS + OEV_W));
    strobes.ckv     = vActive && (hCount >= HW'(CKV_OFS)) &&
                      (hCount < HW'(CKV_OFS + CKV_W));
    strobes.polLoad = (hCount == HW'(POL_OFS));
    strobes.polVal  = vCount[0] ^ frameOdd;
  end

endmodule

// File: rtl/lcdtc_datapath.sv
`timescale 1ns/1ps
module lcdtc_datapath
  import lcdtc_pkg::*;
#(
  parameter int PIX_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  tcStrobes_t       strobes,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic             lcdDe,
  output logic [PIX_W-1:0] lcdRgb,
  output logic             gateStart,
  output logic             gateClk,
  output logic             gateOe,
  output logic             polarity,
  output logic             underflowErr
);

  logic takePix;
  logic missPix;

  assign takePix = strobes.active && pixValid;
  assign missPix = strobes.active && !pixValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcdDe        <= 1'b0;
      lcdRgb       <= '0;
      gateStart    <= 1'b0;
      gateClk      <= 1'b0;
      gateOe       <= 1'b0;
      polarity     <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      lcdDe     <= strobes.active;
      lcdRgb    <= takePix ? pixData : '0;
      gateStart <= strobes.stv;
      gateClk   <= strobes.ckv;
      gateOe    <= strobes.oev;
      if (strobes.polLoad) polarity <= strobes.polVal;
      if (missPix) underflowErr <= 1'b1;
    end
  end

endmodule

// File: rtl/lcd_timing_ctrl.sv
`timescale 1ns/1ps
module lcd_timing_ctrl
  import lcdtc_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_TOTAL  = 1056,
  parameter int V_ACTIVE = 600,
  parameter int VB_MIN   = 10,
  parameter int VB_MAX   = 110,
  parameter int VB_IN_W  = 7,
  parameter int COLOR_W  = 6,
  parameter int STV_OFS  = 4,
  parameter int OEV_OFS  = 23,
  parameter int OEV_W    = 150,
  parameter int CKV_OFS  = 40,
  parameter int CKV_W    = 133,
  parameter int POL_OFS  = 157
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [VB_IN_W-1:0]     vBlankLines,
  input  logic                   pixValid,
  input  logic [3*COLOR_W-1:0]   pixData,
  output logic                   pixReady,
  output logic                   lcdDe,
  output logic [3*COLOR_W-1:0]   lcdRgb,
  output logic                   gateStart,
  output logic                   gateClk,
  output logic                   gateOe,
  output logic                   polarity,
  output logic                   underflowErr
);

  localparam int PIX_W   = 3 * COLOR_W;
  localparam int OEV_END = OEV_OFS + OEV_W;
  localparam int CKV_END = CKV_OFS + CKV_W;
  localparam int STROBE_END = (OEV_END > CKV_END)
                              ? ((OEV_END > POL_OFS + 1) ? OEV_END : POL_OFS + 1)
                              : ((CKV_END > POL_OFS + 1) ? CKV_END : POL_OFS + 1);

  // Strobes must fit inside the horizontal blanking that leads each line
  if (H_TOTAL - H_ACTIVE < STROBE_END) begin : gBadHBlank
    $error("horizontal blanking too short for gate strobes");
  end
  if (V_ACTIVE < 2 || VB_MIN < 1 || VB_MAX < VB_MIN) begin : gBadVert
    $error("illegal vertical configuration");
  end

  tcStrobes_t strobes;

  lcdtc_ctrl #(
    .H_ACTIVE(H_ACTIVE),
    .H_TOTAL (H_TOTAL),
    .V_ACTIVE(V_ACTIVE),
    .VB_MIN  (VB_MIN),
    .VB_MAX  (VB_MAX),
    .VB_IN_W (VB_IN_W),
    .STV_OFS (STV_OFS),
    .OEV_OFS (OEV_OFS),
    .OEV_W   (OEV_W),
    .CKV_OFS (CKV_OFS),
    .CKV_W   (CKV_W),
    .POL_OFS (POL_OFS)
  ) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .vBlankLines(vBlankLines),
    .strobes    (strobes)
  );

  lcdtc_datapath #(
    .PIX_W(PIX_W)
  ) uData (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .pixValid    (pixValid),
    .pixData     (pixData),
    .lcdDe       (lcdDe),
    .lcdRgb      (lcdRgb),
    .gateStart   (gateStart),
    .gateClk     (gateClk),
    .gateOe      (gateOe),
    .polarity    (polarity),
    .underflowErr(underflowErr)
  );

  assign pixReady = strobes.active;

endmodule

// File: rtl/lcd_timing_ctrl_chk.sv
`timescale 1ns/1ps
module lcd_timing_ctrl_chk #(
  parameter int PIX_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             pixValid,
  input logic [PIX_W-1:0] pixData,
  input logic             pixReady,
  input logic             lcdDe,
  input logic [PIX_W-1:0] lcdRgb,
  input logic             gateClk,
  input logic             gateOe,
  input logic             underflowErr
);

  // R6
  rgb_black_chk: assert property (@(posedge clk) disable iff (rst)
    !lcdDe |-> (lcdRgb == '0));

  // R5
  pix_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (pixReady && pixValid) |=> (lcdDe && (lcdRgb == $past(pixData))));

  // R5
  de_follows_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !pixReady |=> !lcdDe);

  // R7
  underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (pixReady && !pixValid) |=> (underflowErr && (lcdRgb == '0)));

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflowErr |=> underflowErr);

  // R8
  ckv_inside_oe_chk: assert property (@(posedge clk) disable iff (rst)
    gateClk |-> gateOe);

endmodule

bind lcd_timing_ctrl lcd_timing_ctrl_chk #(.PIX_W(PIX_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .pixValid    (pixValid),
  .pixData     (pixData),
  .pixReady    (pixReady),
  .lcdDe       (lcdDe),
  .lcdRgb      (lcdRgb),
  .gateClk     (gateClk),
  .gateOe      (gateOe),
  .underflowErr(underflowErr)
);

// File: tb/lcd_timing_ctrl_test.sv
`timescale 1ns/1ps
module lcd_timing_ctrl_test;

  localparam int PERIOD = 26;
  localparam int HA     = 16;
  localparam int HT     = 196;
  localparam int HB     = HT - HA;
  localparam int VA     = 4;
  localparam int WATCHDOG_CYCLES = 190000;

  // blanking request, expected blanking lines
  localparam int VEC [4][2] = '{'{0, 10}, '{12, 12}, '{37, 37}, '{127, 110}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  vBlankLines = 7'd28;
  logic        pixValid = 1'b0;
  logic [17:0] pixData = '0;
  logic        pixReady, lcdDe, gateStart, gateClk, gateOe, polarity, underflowErr;
  logic [17:0] lcdRgb;

  int checks = 0;
  int errors = 0;

  // bench raster model: position currently shown on the outputs
  int mH, mV, mVb, frames, lineDe, frameDe, firstDe, lastFirstDe;
  bit mFrame, mPol, mErr, seenDe;

  always #(PERIOD/2) clk = ~clk;

  lcd_timing_ctrl #(
    .H_ACTIVE(HA),
    .H_TOTAL (HT),
    .V_ACTIVE(VA)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .vBlankLines (vBlankLines),
    .pixValid    (pixValid),
    .pixData     (pixData),
    .pixReady    (pixReady),
    .lcdDe       (lcdDe),
    .lcdRgb      (lcdRgb),
    .gateStart   (gateStart),
    .gateClk     (gateClk),
    .gateOe      (gateOe),
    .polarity    (polarity),
    .underflowErr(underflowErr)
  );

  function automatic int clampVb(int x);
    if (x < 10) return 10;
    if (x > 110) return 110;
    return x;
  endfunction

  function automatic bit modelActive();
    return (mV >= mVb) && (mV < mVb + VA) && (mH >= HB);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (line %0d pos %0d)", req, act, exp, mV, mH);
    end
  endtask

  // Starts and ends at a falling edge; one pixel clock
  task automatic step(bit valid);
    bit vAct, expAct, expStv, expOev, expCkv;
    logic [17:0] offered, expRgb;
    vAct   = (mV >= mVb) && (mV < mVb + VA);
    expAct = vAct && (mH >= HB);
    chk(pixReady == expAct, "R5 ready", int'(pixReady), int'(expAct));
    offered  = 18'((mV * HT + mH) * 97 + 13);
    pixValid = valid;
    pixData  = offered;
    @(posedge clk);
    #1;
    expStv = ((mV == mVb) && (mH >= 4)) || ((mV == mVb + 1) && (mH < 4));
    expOev = vAct && (mH >= 23) && (mH < 173);
    expCkv = vAct && (mH >= 40) && (mH < 173);
    if (mH == 157) mPol = mV[0] ^ mFrame;
    if (expAct && !valid) mErr = 1'b1;
    expRgb = (expAct && valid) ? offered : 18'd0;
    chk(lcdDe == expAct, "R2 data enable", int'(lcdDe), int'(expAct));
    chk(lcdRgb == expRgb, expAct ? (valid ? "R5 pixel" : "R7 black") : "R6 blank rgb",
        int'(lcdRgb), int'(expRgb));
    chk(underflowErr == mErr, "R7 flag", int'(underflowErr), int'(mErr));
    chk(gateStart == expStv, "R9 gateStart", int'(gateStart), int'(expStv));
    chk(gateOe == expOev, "R8 gateOe", int'(gateOe), int'(expOev));
    chk(gateClk == expCkv, "R8 gateClk", int'(gateClk), int'(expCkv));
    chk(polarity == mPol, "R10 polarity", int'(polarity), int'(mPol));
    if (lcdDe) begin
      lineDe++;
      frameDe++;
      if (!seenDe) begin
        firstDe = mV;
        seenDe  = 1'b1;
      end
    end
    if (mH == HT - 1) begin
      chk(lineDe == (vAct ? HA : 0), "R2 line count", lineDe, vAct ? HA : 0);
      lineDe = 0;
      mH = 0;
      if (mV == mVb + VA - 1) begin
        chk(frameDe == HA * VA, "R3 frame count", frameDe, HA * VA);
        lastFirstDe = firstDe;
        seenDe  = 1'b0;
        frameDe = 0;
        mV = 0;
        mFrame = ~mFrame;
        mVb = clampVb(int'(vBlankLines));
        frames++;
      end else begin
        mV++;
      end
    end else begin
      mH++;
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    pixValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!lcdDe && lcdRgb == '0, "R1 reset de/rgb", int'(lcdRgb), 0);
    chk(!gateStart && !gateClk && !gateOe, "R1 reset strobes",
        int'({gateStart, gateClk, gateOe}), 0);
    chk(!polarity && !underflowErr, "R1 reset pol/err", int'({polarity, underflowErr}), 0);
    chk(!pixReady, "R1 reset ready", int'(pixReady), 0);
    @(negedge clk);
    rst = 1'b0;
    mH = 0; mV = 0; mFrame = 1'b0; mPol = 1'b0; mErr = 1'b0;
    mVb = clampVb(int'(vBlankLines));
    lineDe = 0; frameDe = 0; seenDe = 1'b0;
  endtask

  task automatic runFrames(int n);
    int target;
    target = frames + n;
    while (frames < target) step(1'b1);
  endtask

  initial begin
    frames = 0;
    // table of blanking requests, one frame each
    for (int i = 0; i < 4; i++) begin
      vBlankLines = 7'(VEC[i][0]);
      doReset();
      runFrames(1);
      chk(lastFirstDe == VEC[i][1], "R4 blanking lines", lastFirstDe, VEC[i][1]);
    end

    // R7: one missing pixel gives black output and a sticky flag
    vBlankLines = 7'd10;
    doReset();
    while (!modelActive()) step(1'b1);
    step(1'b1);
    step(1'b0);
    chk(underflowErr == 1'b1, "R7 flag set", int'(underflowErr), 1);
    repeat (6) step(1'b1);
    chk(underflowErr == 1'b1, "R7 flag sticky", int'(underflowErr), 1);

    // R4: a mid-frame change waits for the frame boundary
    vBlankLines = 7'd15;
    runFrames(1);
    chk(lastFirstDe == 10, "R4 no change mid-frame", lastFirstDe, 10);
    runFrames(1);
    chk(lastFirstDe == 15, "R4 new value next frame", lastFirstDe, 15);

    // R10: two more frames so the polarity phase flips are observed
    runFrames(2);

    // R1: reset from inside the active region
    while (!modelActive()) step(1'b1);
    repeat (3) step(1'b1);
    doReset();
    repeat (HT * 2) step(1'b1);
    chk(lcdDe == 1'b0, "R1 restart in blanking", int'(lcdDe), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule